// File: doc/BRIEF.md
# 2x2 Matrix Product Register Slave

This block is a memory-mapped slave on a 32-bit AXI4-Lite port. It holds two 2x2 operand matrices, A and B, as eight 32-bit registers. It also exposes their product C = A×B as four read-only result words in the same flat word map.

There is no start command and no busy flag. The product always follows the stored operands. A host writes whichever operand words it wants to change, waits for each write response, and then reads the result words. Each read returns the product of the operands as they stand at that moment.

Each word sits at byte address 4·n, and the low two address bits are ignored. The word map is as follows:

- Words 0..3 hold A in row-major order (A00, A01, A10, A11).
- Words 4..7 hold B in row-major order.
- Words 8..11 hold C in row-major order.
- Words 12..15 read as zero.

Both AXI channel groups are valid/ready handshakes:

- A transfer happens on a clock edge where both valid and ready are high.
- A master that raises valid keeps it, with stable payload, until that edge.
- The slave holds BVALID until BREADY.
- The slave holds RVALID and RDATA until RREADY.
- While a response is pending, the slave deasserts the ready of the matching address channel. This allows at most one outstanding write and one outstanding read.

Top module: `mat2_mul_slave`

## Requirements
- R1: After active-low reset, all sixteen words read as zero, and BVALID and RVALID are low.
- R2: Writes to word indices 0..3 set A in row-major order, and writes to indices 4..7 set B in row-major order. Reading those indices returns the stored values.
- R3: Reading index 8+2i+j returns C[i][j] = A[i][0]·B[0][j] + A[i][1]·B[1][j]. The arithmetic is unsigned and keeps the low 32 bits. For example, A=[1,2,3,4] and B=[5,6,7,8] give 19, 22, 43, 50.
- R4: A read issued right after the write response of an operand write returns the product that includes that write.
- R5: On operand writes, WSTRB bit b enables data byte b (bits 8b+7..8b). Bytes whose strobe is 0 keep their old value.
- R6: Writes to indices 8..15 complete with BRESP OKAY (2'b00) and change no register.
- R7: Reads of indices 12..15 return zero with RRESP OKAY (2'b00).
- R8: The write address and the write data may arrive in either order or in the same cycle. The write takes effect once both have been taken.
- R9: BVALID stays high until BREADY is seen. While BVALID is high, AWREADY and WREADY are low.
- R10: RVALID and RDATA stay unchanged until RREADY is seen. While RVALID is high, ARREADY is low.
- R11: Address bits 1..0 are ignored for both reads and writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | ADDR_W (6) | Write byte address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | DW (32) | Write data |
| s_wstrb | input | DW/8 (4) | Write byte enables |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W (6) | Read byte address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | DW (32) | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |

## Verification
Timing of a write and its effect on the result:

- The operand register is updated on the edge where the later of address and data is taken, and BVALID rises on that same edge.
- The product registers follow one edge later. ARREADY is held low for that cycle, so any read issued after the response sees the new product.
- Read data appears on the edge after the address handshake.

How the bench keeps to that timing:

- It drives at the falling edge and tests the ready flags before the rising edge. The ready flags depend only on registered state.
- It samples BVALID, RVALID and RDATA at falling edges after the handshake edge, and stalls BREADY and RREADY for several cycles to check that responses are held.
- It sweeps about two dozen operand pairs through all three address/data orderings. It checks every operand and result word against a product computed in the bench.

// File: rtl/mm_pkg.sv
package mm_pkg;
  localparam int unsigned MM_DW = 32;
  localparam int unsigned MM_N  = 2;

  typedef enum logic [1:0] {
    RESP_OKAY   = 2'b00,
    RESP_SLVERR = 2'b10
  } resp_e;

  typedef enum logic [1:0] {
    RGN_A    = 2'd0,
    RGN_B    = 2'd1,
    RGN_PROD = 2'd2,
    RGN_NONE = 2'd3
  } region_e;

  function automatic region_e region_of(input int ix, input int nn);
    if (ix < nn)          return RGN_A;
    else if (ix < 2 * nn) return RGN_B;
    else if (ix < 3 * nn) return RGN_PROD;
    else                  return RGN_NONE;
  endfunction
endpackage

// File: rtl/mm_wr_chan.sv
module mm_wr_chan #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DW     = 32,
  localparam int unsigned IDX_W = ADDR_W - 2,
  localparam int unsigned SB    = DW / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              awvalid,
  output logic              awready,
  input  logic [DW-1:0]     wdata,
  input  logic [SB-1:0]     wstrb,
  input  logic              wvalid,
  output logic              wready,
  output logic [1:0]        bresp,
  output logic              bvalid,
  input  logic              bready,
  output logic              we,
  output logic [IDX_W-1:0]  widx,
  output logic [DW-1:0]     wd,
  output logic [SB-1:0]     ws
);
  logic             aw_full, w_full, bvalid_q;
  logic [IDX_W-1:0] aw_q;
  logic [DW-1:0]    w_q;
  logic [SB-1:0]    s_q;
  logic             aw_hs, w_hs, aw_have, w_have, fire;

  assign awready = !aw_full && !bvalid_q;
  assign wready  = !w_full && !bvalid_q;
  assign aw_hs   = awvalid && awready;
  assign w_hs    = wvalid && wready;
  assign aw_have = aw_full || aw_hs;
  assign w_have  = w_full || w_hs;
  assign fire    = aw_have && w_have;

  assign we   = fire;
  assign widx = aw_full ? aw_q : awaddr[ADDR_W-1:2];
  assign wd   = w_full ? w_q : wdata;
  assign ws   = w_full ? s_q : wstrb;

  assign bvalid = bvalid_q;
  assign bresp  = mm_pkg::RESP_OKAY;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aw_full  <= 1'b0;
      w_full   <= 1'b0;
      bvalid_q <= 1'b0;
      aw_q     <= '0;
      w_q      <= '0;
      s_q      <= '0;
    end else begin
      if (fire) begin
        aw_full  <= 1'b0;
        w_full   <= 1'b0;
        bvalid_q <= 1'b1;
      end else begin
        if (aw_hs) begin
          aw_full <= 1'b1;
          aw_q    <= awaddr[ADDR_W-1:2];
        end
        if (w_hs) begin
          w_full <= 1'b1;
          w_q    <= wdata;
          s_q    <= wstrb;
        end
        if (bvalid_q && bready) bvalid_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mm_opnd_regs.sv
module mm_opnd_regs #(
  parameter int unsigned N      = 2,
  parameter int unsigned DW     = 32,
  parameter int unsigned IDX_W  = 4,
  localparam int unsigned NN    = N * N,
  localparam int unsigned WORDS = 2 * NN,
  localparam int unsigned SB    = DW / 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [IDX_W-1:0]    widx,
  input  logic [DW-1:0]       wd,
  input  logic [SB-1:0]       ws,
  output logic [WORDS*DW-1:0] opnd,
  output logic                upd
);
  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic [DW-1:0] word_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (we && (widx == IDX_W'(g))) begin
        for (int b = 0; b < SB; b++) begin
          if (ws[b]) word_q[b*8 +: 8] <= wd[b*8 +: 8];
        end
      end
    end
    assign opnd[g*DW +: DW] = word_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) upd <= 1'b0;
    else        upd <= we;
  end
endmodule

// File: rtl/mm_mac.sv
module mm_mac #(
  parameter int unsigned N  = 2,
  parameter int unsigned DW = 32,
  localparam int unsigned NN = N * N
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2*NN*DW-1:0]    opnd,
  output logic [NN*DW-1:0]      prod
);
  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      logic [DW-1:0] acc;
      logic [DW-1:0] acc_q;
      always_comb begin
        acc = '0;
        for (int k = 0; k < N; k++) begin
          acc = acc + opnd[(i*N + k)*DW +: DW] * opnd[(NN + k*N + j)*DW +: DW];
        end
      end
      always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc;
      end
      assign prod[(i*N + j)*DW +: DW] = acc_q;
    end
  end
endmodule

// File: rtl/mm_rd_chan.sv
module mm_rd_chan #(
  parameter int unsigned N      = 2,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DW     = 32,
  localparam int unsigned NN    = N * N,
  localparam int unsigned IDX_W = ADDR_W - 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  araddr,
  input  logic               arvalid,
  output logic               arready,
  output logic [DW-1:0]      rdata,
  output logic [1:0]         rresp,
  output logic               rvalid,
  input  logic               rready,
  input  logic [2*NN*DW-1:0] opnd,
  input  logic [NN*DW-1:0]   prod,
  input  logic               hold
);
  import mm_pkg::*;

  logic          rvalid_q;
  logic [DW-1:0] rdata_q, sel;
  logic [IDX_W-1:0] idx;

  assign idx     = araddr[ADDR_W-1:2];
  assign arready = !rvalid_q && !hold;
  assign rvalid  = rvalid_q;
  assign rdata   = rdata_q;
  assign rresp   = RESP_OKAY;

  always_comb begin
    int ix;
    ix  = int'(idx);
    sel = '0;
    unique case (region_of(ix, NN))
      RGN_A, RGN_B: sel = opnd[ix*DW +: DW];
      RGN_PROD:     sel = prod[(ix - 2*NN)*DW +: DW];
      default:      sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else if (arvalid && arready) begin
      rvalid_q <= 1'b1;
      rdata_q  <= sel;
    end else if (rvalid_q && rready) begin
      rvalid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/mat2_mul_slave.sv
module mat2_mul_slave #(
  parameter int unsigned N      = mm_pkg::MM_N,
  parameter int unsigned DW     = mm_pkg::MM_DW,
  parameter int unsigned ADDR_W = 6,
  localparam int unsigned NN    = N * N,
  localparam int unsigned IDX_W = ADDR_W - 2,
  localparam int unsigned SB    = DW / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [DW-1:0]     s_wdata,
  input  logic [SB-1:0]     s_wstrb,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [DW-1:0]     s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready
);
  logic                 we, upd;
  logic [IDX_W-1:0]     widx;
  logic [DW-1:0]        wd;
  logic [SB-1:0]        ws;
  logic [2*NN*DW-1:0]   opnd;
  logic [NN*DW-1:0]     prod;

  mm_wr_chan #(.ADDR_W(ADDR_W), .DW(DW)) u_wr (
    .clk(clk), .rst_n(rst_n),
    .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
    .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
    .bresp(s_bresp), .bvalid(s_bvalid), .bready(s_bready),
    .we(we), .widx(widx), .wd(wd), .ws(ws)
  );

  mm_opnd_regs #(.N(N), .DW(DW), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(we), .widx(widx), .wd(wd), .ws(ws),
    .opnd(opnd), .upd(upd)
  );

  mm_mac #(.N(N), .DW(DW)) u_mac (
    .clk(clk), .rst_n(rst_n), .opnd(opnd), .prod(prod)
  );

  mm_rd_chan #(.N(N), .ADDR_W(ADDR_W), .DW(DW)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
    .rdata(s_rdata), .rresp(s_rresp), .rvalid(s_rvalid), .rready(s_rready),
    .opnd(opnd), .prod(prod), .hold(upd)
  );
endmodule

// File: rtl/mm_chk.sv
module mm_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          s_awready,
  input logic          s_wready,
  input logic [1:0]    s_bresp,
  input logic          s_bvalid,
  input logic          s_bready,
  input logic          s_arready,
  input logic [DW-1:0] s_rdata,
  input logic [1:0]    s_rresp,
  input logic          s_rvalid,
  input logic          s_rready
);
  // R9
  bvalid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_bvalid && !s_bready |=> s_bvalid);
  // R9
  one_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_bvalid |-> !s_awready && !s_wready);
  // R10
  rvalid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata));
  // R10
  one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid |-> !s_arready);
  // R6
  bresp_okay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_bvalid |-> s_bresp == 2'b00);
  // R7
  rresp_okay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid |-> s_rresp == 2'b00);
endmodule

bind mat2_mul_slave mm_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .s_awready(s_awready), .s_wready(s_wready),
  .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
  .s_arready(s_arready), .s_rdata(s_rdata), .s_rresp(s_rresp),
  .s_rvalid(s_rvalid), .s_rready(s_rready)
);

// File: tb/tb_mat2_mul_slave.sv
module tb_mat2_mul_slave;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] s_awaddr = '0, s_araddr = '0;
  logic s_awvalid = 0, s_wvalid = 0, s_bready = 0, s_arvalid = 0, s_rready = 0;
  logic [31:0] s_wdata = '0;
  logic [3:0]  s_wstrb = '0;
  logic s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
  logic [1:0] s_bresp, s_rresp;
  logic [31:0] s_rdata;

  int n_run = 0, n_fail = 0;
  bit finished = 0;
  logic [31:0] ma [4];
  logic [31:0] mb [4];

  always #4 clk = ~clk;

  mat2_mul_slave dut (
    .clk(clk), .rst_n(rst_n),
    .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
    .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] cexp(input int i, input int j);
    return ma[i*2] * mb[j] + ma[i*2+1] * mb[2+j];
  endfunction

  // mode 0: AW and W together, 1: AW first, 2: W first
  task automatic axi_wr(input logic [AW-1:0] addr, input logic [31:0] data,
                        input logic [3:0] strb, input int mode, input int bdly);
    bit aw_done = 0, w_done = 0, aw_ok, w_ok;
    @(negedge clk);
    s_awaddr = addr; s_wdata = data; s_wstrb = strb;
    if (mode != 2) s_awvalid = 1;
    if (mode != 1) s_wvalid = 1;
    while (!(aw_done && w_done)) begin
      #1;
      aw_ok = s_awvalid && s_awready;
      w_ok  = s_wvalid && s_wready;
      @(posedge clk);
      @(negedge clk);
      if (aw_ok) begin s_awvalid = 0; aw_done = 1; end
      if (w_ok)  begin s_wvalid = 0;  w_done = 1;  end
      if (aw_done && !w_done && !s_wvalid) s_wvalid = 1;
      if (w_done && !aw_done && !s_awvalid) s_awvalid = 1;
    end
    for (int d = 0; d < bdly; d++) @(negedge clk);
    if (bdly > 0) check("R9 bvalid held", 32'(s_bvalid), 32'd1);
    s_bready = 1;
    while (!s_bvalid) @(negedge clk);
    check("R6 bresp okay", 32'(s_bresp), 32'd0);
    @(posedge clk);
    @(negedge clk);
    s_bready = 0;
  endtask

  task automatic axi_rd(input logic [AW-1:0] addr, input int rdly, output logic [31:0] data);
    bit ok = 0;
    logic [31:0] first;
    @(negedge clk);
    s_araddr = addr; s_arvalid = 1;
    while (!ok) begin
      #1;
      ok = s_arready;
      @(posedge clk);
      @(negedge clk);
    end
    s_arvalid = 0;
    first = s_rdata;
    for (int d = 0; d < rdly; d++) @(negedge clk);
    if (rdly > 0) begin
      check("R10 rvalid held", 32'(s_rvalid), 32'd1);
      check("R10 rdata stable", s_rdata, first);
    end
    s_rready = 1;
    while (!s_rvalid) @(negedge clk);
    data = s_rdata;
    check("R7 rresp okay", 32'(s_rresp), 32'd0);
    @(posedge clk);
    @(negedge clk);
    s_rready = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, seed;
    repeat (3) @(negedge clk);
    check("R1 bvalid low", 32'(s_bvalid), 32'd0);
    check("R1 rvalid low", 32'(s_rvalid), 32'd0);
    rst_n = 1;
    for (int w = 0; w < 16; w++) begin
      axi_rd(AW'(w*4), 0, rd);
      check(w >= 12 ? "R7 unused word zero" : "R1 reset zero", rd, 32'd0);
    end

    // known product: R3
    for (int k = 0; k < 4; k++) begin ma[k] = 32'(k+1); mb[k] = 32'(k+5); end
    for (int k = 0; k < 4; k++) axi_wr(AW'(k*4), ma[k], 4'hF, k % 3, 0);
    for (int k = 0; k < 4; k++) axi_wr(AW'(16 + k*4), mb[k], 4'hF, 0, 0);
    axi_rd(AW'(32), 0, rd); check("R3 C00=19", rd, 32'd19);
    axi_rd(AW'(36), 0, rd); check("R3 C01=22", rd, 32'd22);
    axi_rd(AW'(40), 0, rd); check("R3 C10=43", rd, 32'd43);
    axi_rd(AW'(44), 0, rd); check("R3 C11=50", rd, 32'd50);

    // sweep: R2 R3 R4 R8
    seed = 32'h1234_5678;
    for (int t = 0; t < 24; t++) begin
      for (int k = 0; k < 8; k++) begin
        seed = seed * 32'd1664525 + 32'd1013904223;
        if (k < 4) ma[k] = (t < 8) ? {28'd0, seed[31:28]} : seed;
        else       mb[k-4] = (t < 8) ? {28'd0, seed[31:28]} : seed;
      end
      for (int k = 0; k < 4; k++) axi_wr(AW'(k*4), ma[k], 4'hF, (t + k) % 3, t % 3);
      for (int k = 0; k < 4; k++) axi_wr(AW'(16 + k*4), mb[k], 4'hF, (t + k + 1) % 3, 0);
      for (int k = 0; k < 4; k++) begin
        axi_rd(AW'(k*4), 0, rd);      check("R2 A readback", rd, ma[k]);
        axi_rd(AW'(16 + k*4), 0, rd); check("R2 B readback", rd, mb[k]);
      end
      for (int k = 0; k < 4; k++) begin
        axi_rd(AW'(32 + k*4), t % 4, rd);
        check("R3 R8 product", rd, cexp(k / 2, k % 2));
      end
      // single operand update then immediate read: R4
      ma[t % 4] = ma[t % 4] + 32'd7;
      axi_wr(AW'((t % 4) * 4), ma[t % 4], 4'hF, t % 3, 0);
      axi_rd(AW'(32 + (t % 4 / 2) * 8), 0, rd);
      check("R4 fresh product", rd, cexp(t % 4 / 2, 0));
    end

    // byte strobes: R5
    ma[0] = 32'hAABBCCDD;
    axi_wr(AW'(0), ma[0], 4'hF, 0, 0);
    axi_wr(AW'(0), 32'h11223344, 4'b0101, 1, 0);
    ma[0] = 32'hAA22CC44;
    axi_rd(AW'(0), 0, rd); check("R5 strobe merge", rd, ma[0]);
    mb[5 - 4] = mb[1];
    axi_wr(AW'(28), 32'h0000_00FF, 4'b0001, 2, 0);
    mb[3] = {mb[3][31:8], 8'hFF};
    axi_rd(AW'(28), 0, rd); check("R5 strobe low byte", rd, mb[3]);
    axi_rd(AW'(32), 0, rd); check("R5 product after strobe", rd, cexp(0, 0));

    // writes to result and unused words ignored: R6
    axi_wr(AW'(32), 32'hDEADBEEF, 4'hF, 0, 2);
    axi_wr(AW'(52), 32'hCAFEF00D, 4'hF, 1, 0);
    axi_rd(AW'(32), 0, rd); check("R6 C00 unchanged", rd, cexp(0, 0));
    axi_rd(AW'(52), 0, rd); check("R6 R7 unused still zero", rd, 32'd0);
    for (int k = 0; k < 4; k++) begin
      axi_rd(AW'(k*4), 0, rd); check("R6 A unchanged", rd, ma[k]);
    end

    // low address bits ignored: R11
    ma[3] = 32'h0000_0100;
    axi_wr(AW'(12 + 3), ma[3], 4'hF, 2, 0);
    axi_rd(AW'(12 + 1), 0, rd); check("R11 offset address write/read", rd, ma[3]);
    axi_rd(AW'(44 + 2), 0, rd); check("R11 product offset read", rd, cexp(1, 1));

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule